// File: doc/BRIEF.md
# Status-Change Interrupt Aggregator

This block collects four banks of per-channel condition flags and turns them into one active-low interrupt request. The four banks carry loss of signal, transmit driver fault, alarm-indication-signal detect and waveform-sum overflow. The detectors that produce these flags sit outside the block, and each bank arrives as an 8-bit input vector. For every bank the block holds a sampled live status byte, a mask byte written by the host, and a sticky change byte. A bit of the change byte is set when the matching live bit toggles in either direction while its mask bit is 1.

The host uses a strobe-based register port with an 8-bit address and 8-bit data. A read of a change byte returns its value and clears it in the same access. A write of any value to the software-reset address returns every register to zero. A two-state machine owns the pin. In state `IRQ_IDLE` the pin is high. The transition `raise` moves it to `IRQ_ACTIVE`, where the pin is low, when any masked change bit is pending. The transition `release` returns it to `IRQ_IDLE` when no masked change bit remains. Each state holds when its condition is absent.

Top module: `status_irq_agg`

## Requirements
- R1: After reset every readable register returns 00h and `irq_n` is 1.
- R2: The live status bytes read at 04h (loss), 05h (driver fault) and 13h (alarm detect) return the input vector as sampled one clock earlier. The overflow bank has no status address.
- R3: The mask bytes are read and written at 06h (loss), 07h (driver fault), 14h (alarm detect) and 1Ah (overflow). Writes to status or change addresses have no effect.
- R4: A toggle of live bit n, rising or falling, while mask bit n is 1 sets bit n of that bank's change byte. The change bytes are at 08h, 09h, 15h and 1Bh.
- R5: A toggle of live bit n while mask bit n is 0 leaves change bit n at 0.
- R6: A read of a change byte returns its value before clearing, and the byte reads 00h afterwards.
- R7: A change that is latched in the same cycle as a clearing read of its byte stays set after the read.
- R8: `irq_n` goes to 0 one clock after any change bit with its mask bit at 1 is set. It returns to 1 one clock after no such bit remains. A latched bit whose mask bit was later cleared does not hold the pin low, and that bit stays readable.
- R9: Clearing a mask bit leaves the live status byte unchanged.
- R10: A write of any value to 0Ah zeroes every mask and change byte and releases `irq_n`. The live status bytes then reload from the inputs.
- R11: A read of an address that no register occupies returns 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; clears the addressed change byte at the clock edge |
| host_addr | input | 8 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while `host_rd` is high |
| los_in | input | 8 | Loss-of-signal flags per channel |
| drv_fault_in | input | 8 | Driver-fault flags per channel |
| alarm_in | input | 8 | Alarm-indication detect flags per channel |
| ovf_in | input | 8 | Waveform overflow flags per channel |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is a new toggle that lands in exactly the clock where the host's clearing read of the same change byte takes effect. That toggle must survive the read (R7). The bench first latches one bit. It then moves a different input bit at a falling edge and issues the read one cycle later. This places the read inside the single cycle in which the sampled and previous values differ. The bench then expects the old bit in the read data and only the new bit afterwards. A second awkward case is a latched bit whose mask is withdrawn afterwards. The bench checks that the pin rises while the bit stays readable.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int CH_W   = 8;
    localparam int ADDR_W = 8;
    localparam int NGRP   = 4;

    // bank order: loss, driver fault, alarm detect, overflow
    localparam logic [ADDR_W-1:0] STAT_ADDR [NGRP] = '{8'h04, 8'h05, 8'h13, 8'h00};
    localparam logic [NGRP-1:0]   HAS_STAT         = 4'b0111;
    localparam logic [ADDR_W-1:0] MASK_ADDR [NGRP] = '{8'h06, 8'h07, 8'h14, 8'h1A};
    localparam logic [ADDR_W-1:0] CHG_ADDR  [NGRP] = '{8'h08, 8'h09, 8'h15, 8'h1B};
    localparam logic [ADDR_W-1:0] SRST_ADDR        = 8'h0A;

    typedef enum logic {IRQ_IDLE, IRQ_ACTIVE} irq_state_e;
endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         soft_clr,
    input  logic [W-1:0] flags_in,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic         chg_rd,
    output logic [W-1:0] live_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] chg_q,
    output logic         pending
);
    logic [W-1:0] prev_q;
    logic [W-1:0] toggled;
    logic [W-1:0] hit;

    assign toggled = live_q ^ prev_q;
    assign hit     = toggled & mask_q;
    assign pending = |(chg_q & mask_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= '0;
            prev_q <= '0;
            mask_q <= '0;
            chg_q  <= '0;
        end else if (soft_clr) begin
            live_q <= '0;
            prev_q <= '0;
            mask_q <= '0;
            chg_q  <= '0;
        end else begin
            live_q <= flags_in;
            prev_q <= live_q;
            if (mask_we) mask_q <= mask_wdata;
            // new toggles take priority over the clearing read
            chg_q <= (chg_rd ? '0 : chg_q) | hit;
        end
    end

    // R4: a masked toggle is latched on the next edge
    a_r4_latch_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!soft_clr && |hit) |=> ((chg_q & $past(hit)) == $past(hit)));

    // R5: no bit becomes set without a masked toggle
    a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((chg_q & ~$past(chg_q) & ~$past(hit)) == '0));

    // R6: a read with no new toggle empties the byte
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_rd && hit == '0) |=> (chg_q == '0));

    // R9: a mask write does not disturb live status beyond input sampling
    a_r9_live_indep: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !soft_clr && $stable(flags_in)) |=> (live_q == $past(flags_in)));
endmodule

// File: rtl/irq_pin_fsm.sv
module irq_pin_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_pending,
    output logic irq_n
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (any_pending)  state_d = IRQ_ACTIVE;  // raise
            IRQ_ACTIVE: if (!any_pending) state_d = IRQ_IDLE;    // release
            default:                      state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != IRQ_ACTIVE);
    end

    // R8: pin follows pending state one clock later
    a_r8_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        any_pending |=> !irq_n);
    a_r8_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pending |=> irq_n);
endmodule

// File: rtl/status_irq_agg.sv
module status_irq_agg
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [CH_W-1:0]   host_wdata,
    output logic [CH_W-1:0]   host_rdata,
    input  logic [CH_W-1:0]   los_in,
    input  logic [CH_W-1:0]   drv_fault_in,
    input  logic [CH_W-1:0]   alarm_in,
    input  logic [CH_W-1:0]   ovf_in,
    output logic              irq_n
);
    logic [CH_W-1:0] flags   [NGRP];
    logic [CH_W-1:0] live    [NGRP];
    logic [CH_W-1:0] mask    [NGRP];
    logic [CH_W-1:0] chg     [NGRP];
    logic [NGRP-1:0] pend;
    logic            soft_clr;

    assign flags[0] = los_in;
    assign flags[1] = drv_fault_in;
    assign flags[2] = alarm_in;
    assign flags[3] = ovf_in;
    assign soft_clr = host_wr && (host_addr == SRST_ADDR);

    for (genvar g = 0; g < NGRP; g++) begin : g_bank
        logic mask_we, chg_rd;
        assign mask_we = host_wr && (host_addr == MASK_ADDR[g]);
        assign chg_rd  = host_rd && (host_addr == CHG_ADDR[g]);
        irq_bank #(.W(CH_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
            .flags_in(flags[g]), .mask_we(mask_we), .mask_wdata(host_wdata),
            .chg_rd(chg_rd), .live_q(live[g]), .mask_q(mask[g]),
            .chg_q(chg[g]), .pending(pend[g])
        );
    end

    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            for (int g = 0; g < NGRP; g++) begin
                if (HAS_STAT[g] && host_addr == STAT_ADDR[g]) host_rdata = live[g];
                if (host_addr == MASK_ADDR[g])                host_rdata = mask[g];
                if (host_addr == CHG_ADDR[g])                 host_rdata = chg[g];
            end
        end
    end

    irq_pin_fsm u_pin (
        .clk(clk), .rst_n(rst_n), .any_pending(|pend), .irq_n(irq_n)
    );

    // R10: software reset empties masks and change bytes
    a_r10_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (mask[0] == '0 && mask[1] == '0 && mask[2] == '0 && mask[3] == '0
                      && chg[0] == '0 && chg[1] == '0 && chg[2] == '0 && chg[3] == '0));

    // R3: mask byte only moves on its own write or a software reset
    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(mask[0]));
endmodule

// File: tb/sim_status_irq_agg.sv
module sim_status_irq_agg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] los_in = '0, drv_fault_in = '0, alarm_in = '0, ovf_in = '0;
    logic       irq_n;
    int         total = 0, bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    status_irq_agg u0 (.*);

    // ops: 0 write, 1 read-check, 2 set bank input (addr = bank), 3 pin check (exp[0])
    localparam int N = 44;
    localparam logic [33:0] VEC [N] = '{
        {2'd0, 8'h06, 8'hFF, 8'h00, 8'd3},  // R3 mask loss
        {2'd2, 8'h00, 8'h05, 8'h00, 8'd2},
        {2'd1, 8'h04, 8'h00, 8'h05, 8'd2},  // R2
        {2'd3, 8'h00, 8'h00, 8'h00, 8'd8},  // R8 low
        {2'd1, 8'h08, 8'h00, 8'h05, 8'd6},  // R6 pre-clear value
        {2'd1, 8'h08, 8'h00, 8'h00, 8'd6},  // R6 cleared
        {2'd3, 8'h00, 8'h00, 8'h01, 8'd8},  // R8 released
        {2'd2, 8'h00, 8'h04, 8'h00, 8'd4},  // falling edge bit0
        {2'd1, 8'h08, 8'h00, 8'h01, 8'd4},  // R4
        {2'd0, 8'h07, 8'h0F, 8'h00, 8'd3},
        {2'd2, 8'h01, 8'hF0, 8'h00, 8'd5},  // masked toggles
        {2'd1, 8'h09, 8'h00, 8'h00, 8'd5},  // R5
        {2'd3, 8'h00, 8'h00, 8'h01, 8'd5},
        {2'd1, 8'h05, 8'h00, 8'hF0, 8'd2},
        {2'd2, 8'h01, 8'hF3, 8'h00, 8'd4},
        {2'd1, 8'h09, 8'h00, 8'h03, 8'd4},
        {2'd0, 8'h14, 8'h80, 8'h00, 8'd3},
        {2'd2, 8'h02, 8'h80, 8'h00, 8'd4},
        {2'd1, 8'h15, 8'h00, 8'h80, 8'd4},
        {2'd1, 8'h13, 8'h00, 8'h80, 8'd2},
        {2'd0, 8'h1A, 8'h01, 8'h00, 8'd3},
        {2'd2, 8'h03, 8'h01, 8'h00, 8'd4},
        {2'd1, 8'h1B, 8'h00, 8'h01, 8'd4},
        {2'd0, 8'h04, 8'hAA, 8'h00, 8'd3},  // write to status ignored
        {2'd1, 8'h04, 8'h00, 8'h04, 8'd3},
        {2'd1, 8'h06, 8'h00, 8'hFF, 8'd3},
        {2'd1, 8'h1A, 8'h00, 8'h01, 8'd3},
        {2'd1, 8'h30, 8'h00, 8'h00, 8'd11}, // R11
        {2'd0, 8'h06, 8'h00, 8'h00, 8'd9},
        {2'd1, 8'h04, 8'h00, 8'h04, 8'd9},  // R9
        {2'd0, 8'h06, 8'h01, 8'h00, 8'd8},
        {2'd2, 8'h00, 8'h05, 8'h00, 8'd8},
        {2'd3, 8'h00, 8'h00, 8'h00, 8'd8},
        {2'd0, 8'h06, 8'h00, 8'h00, 8'd8},  // withdraw mask
        {2'd3, 8'h00, 8'h00, 8'h01, 8'd8},
        {2'd1, 8'h08, 8'h00, 8'h01, 8'd8},
        {2'd0, 8'h06, 8'hFF, 8'h00, 8'd10},
        {2'd2, 8'h00, 8'h00, 8'h00, 8'd10},
        {2'd3, 8'h00, 8'h00, 8'h00, 8'd10},
        {2'd0, 8'h0A, 8'h5A, 8'h00, 8'd10}, // R10 soft reset
        {2'd1, 8'h06, 8'h00, 8'h00, 8'd10},
        {2'd1, 8'h08, 8'h00, 8'h00, 8'd10},
        {2'd3, 8'h00, 8'h00, 8'h01, 8'd10},
        {2'd1, 8'h04, 8'h00, 8'h00, 8'd10}
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_read(input int req, input logic [7:0] a, input logic [7:0] exp);
        host_rd = 1'b1; host_addr = a;
        #5 check(req, host_rdata, exp);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic set_bank(input logic [7:0] b, input logic [7:0] v);
        case (b)
            8'd0: los_in = v;
            8'd1: drv_fault_in = v;
            8'd2: alarm_in = v;
            default: ovf_in = v;
        endcase
        repeat (3) @(negedge clk);
    endtask

    task automatic pin_check(input int req, input logic e);
        repeat (2) @(negedge clk);
        check(req, {7'd0, irq_n}, {7'd0, e});
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(1, {7'd0, irq_n}, 8'h01);
        do_read(1, 8'h06, 8'h00);
        do_read(1, 8'h08, 8'h00);
        do_read(1, 8'h1B, 8'h00);

        for (int i = 0; i < N; i++) begin
            logic [1:0] op;
            logic [7:0] a, d, e, rq;
            {op, a, d, e, rq} = VEC[i];
            case (op)
                2'd0: do_write(a, d);
                2'd1: do_read(int'(rq), a, e);
                2'd2: set_bank(a, d);
                default: pin_check(int'(rq), e[0]);
            endcase
        end

        // R7: toggle latched in the same cycle as a clearing read survives
        do_write(8'h06, 8'hFF);
        set_bank(8'd0, 8'h02);
        los_in = 8'h06;
        @(negedge clk);
        do_read(7, 8'h08, 8'h02);
        do_read(7, 8'h08, 8'h04);
        pin_check(7, 1'b1);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL R0 watchdog actual=running expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule